// File: doc/BRIEF.md
# Secure-module interface bring-up sequencer

This block is a host-side state machine that prepares a memory-mapped security-module register interface once reset is released. It works without software and without an outside start signal. It drives a simple master bus, which carries an address, a byte or word size, a read/write flag and write data. A ready signal from the slave completes each access. It performs the whole start-up sequence on that bus. First it waits for the access register to report that its contents are valid. It then confirms that a device is present and that the device offers the capabilities the host requires. It switches off the module's global interrupt enable, so the interface works by polling. It makes sure that locality 0 is held. Last, it records the device identifier and revision.

When the sequence finishes, the block raises a done flag and presents the 32-bit identifier and the 8-bit revision. If the sequence fails, the block raises an error flag with a two-bit code that says which stage failed. In either case the block leaves the bus idle until the next reset. All waits are counted in clock cycles. A microsecond tick is derived from a clock-frequency parameter.

Top module: `smi_bringup`

## Requirements
- R1: While reset is asserted and right after it, `req_valid`, `init_done` and `init_error` are 0 and `err_code` is 0.
- R2: The block polls the access register (offset 0x000) with byte reads. The read data's bit 7 marks validity. Consecutive polls are spaced at least `POLL_GAP_US` microseconds apart, and the block moves on at the first read that has bit 7 set.
- R3: If `POLL_LIMIT` polls in a row return bit 7 clear, the block stops with `init_error`=1 and `err_code`=1, and makes no further access.
- R4: After validity, the block makes a word read of the capability register at offset 0x014. A value of 0xFFFFFFFF ends the sequence with `err_code`=2.
- R5: The capability word must have bits 0, 2 and 4 set, and also bit 5 or bit 4. Any other value ends the sequence with `err_code`=3.
- R6: The block reads the interrupt-enable register (offset 0x008) as a word. It writes the register back as a word, with bits 7, 2, 1 and 0 set and bit 31 cleared, and every other bit unchanged.
- R7: The block then makes a byte read of the access register. If bits 7 and 5 are both set, locality 0 is already held, and no request is written.
- R8: Otherwise the block writes the byte 0x02 to offset 0x000. It then re-reads that register until bits 7 and 5 are both set.
- R9: If locality is not held within `LOC_TIMEOUT_US` microseconds of the request write, the sequence ends with `err_code`=3.
- R10: Once locality is held, the block makes a word read at 0xF00 and a byte read at 0xF04. It then raises `init_done`, with `dev_id` equal to the word and `dev_rev` equal to the low byte of the byte read.
- R11: A request holds its address, direction, size and write data steady while `req_valid` is high and `bus_ready` is low. An access completes on the clock edge where both are high, and `req_valid` is low in the following cycle.
- R12: `init_done` and `init_error` are never both high. Once either is set it stays set until reset, and `req_valid` stays low after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Bus request pending |
| req_addr | output | 16 | Register byte offset |
| req_write | output | 1 | 1 = write, 0 = read |
| req_size | output | 1 | 0 = byte, 1 = 32-bit word |
| req_wdata | output | 32 | Write data (byte writes use bits 7:0) |
| bus_ready | input | 1 | Slave completes the request on this edge |
| bus_rdata | input | 32 | Read data, valid while bus_ready is high |
| init_done | output | 1 | Sequence completed |
| init_error | output | 1 | Sequence aborted |
| err_code | output | 2 | 0 none, 1 validity timeout, 2 no device, 3 refused or locality timeout |
| dev_id | output | 32 | Captured device identifier |
| dev_rev | output | 8 | Captured revision |

## Verification
The bench runs as the bus slave, with a chosen ready latency. It compares each access against a queue of expected accesses when that access is accepted, that is, in the cycle where the bench raises `bus_ready`. The done and error flags follow the final accepted access by two cycles: one cycle for the completion pulse and one for the state update. For that reason the bench checks them on every clock, and checks the final values only after the accesses run out. Timed behaviour is measured in clock cycles between acceptance edges. The validity-poll spacing must be at least `POLL_GAP_US`×`CLK_MHZ` cycles. The locality timeout must fall between that bound and one poll period beyond it.

// File: rtl/smi_pkg.sv
package smi_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ACCESS = 16'h0000;
    localparam logic [ADDR_W-1:0] OFS_INTEN  = 16'h0008;
    localparam logic [ADDR_W-1:0] OFS_CAPS   = 16'h0014;
    localparam logic [ADDR_W-1:0] OFS_DEVID  = 16'h0F00;
    localparam logic [ADDR_W-1:0] OFS_DEVREV = 16'h0F04;

    localparam int ACC_VALID_BIT  = 7;
    localparam int ACC_ACTIVE_BIT = 5;
    localparam logic [7:0] ACC_REQ_USE = 8'h02;

    localparam logic [DATA_W-1:0] CAPS_MUST    = 32'h0000_0015;
    localparam logic [DATA_W-1:0] CAPS_ANY_OF  = 32'h0000_0030;
    localparam logic [DATA_W-1:0] INTEN_SET    = 32'h0000_0087;
    localparam logic [DATA_W-1:0] INTEN_CLEAR  = 32'h8000_0000;

    typedef enum logic [3:0] {
        ST_VPOLL, ST_VWAIT, ST_CAP, ST_IE_RD, ST_IE_WR,
        ST_LOC_CHK, ST_LOC_REQ, ST_LOC_POLL, ST_ID, ST_REV,
        ST_DONE, ST_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_NOT_VALID = 2'd1,
        ERR_ABSENT    = 2'd2,
        ERR_REFUSED   = 2'd3
    } err_e;

    typedef struct packed {
        logic              write;
        logic              size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

endpackage

// File: rtl/smi_us_timer.sv
module smi_us_timer #(
    parameter int CLK_MHZ = 100,
    parameter int US_W    = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [US_W-1:0] load_us,
    output logic            expired
);
    localparam int CYC_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_MHZ - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [US_W-1:0]  us;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.cyc = '0;
            d.us  = load_us;
        end else if (q.us != '0) begin
            if (q.cyc == CYC_LAST) begin
                d.cyc = '0;
                d.us  = q.us - 1'b1;
            end else begin
                d.cyc = q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = (q.us == '0);

endmodule

// File: rtl/smi_bus_port.sv
module smi_bus_port
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  bus_cmd_t          cmd,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              req_valid,
    output bus_cmd_t          req_cmd,
    output logic              xfer_done,
    output logic [DATA_W-1:0] xfer_rdata
);
    typedef struct packed {
        logic              valid;
        bus_cmd_t          cmd;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.valid) begin
            if (bus_ready) begin
                d.valid = 1'b0;
                d.done  = 1'b1;
                d.rdata = bus_rdata;
            end
        end else if (go) begin
            d.valid = 1'b1;
            d.cmd   = cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_valid  = q.valid;
    assign req_cmd    = q.cmd;
    assign xfer_done  = q.done;
    assign xfer_rdata = q.rdata;

endmodule

// File: rtl/smi_seq.sv
module smi_seq
    import smi_pkg::*;
#(
    parameter int POLL_LIMIT     = 10000,
    parameter int POLL_GAP_US    = 10,
    parameter int LOC_TIMEOUT_US = 2000000,
    parameter int US_W           = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_rdata,
    input  logic              tmr_expired,
    output logic              go,
    output bus_cmd_t          cmd,
    output logic              tmr_load,
    output logic [US_W-1:0]   tmr_load_us,
    output logic              init_done,
    output logic              init_error,
    output logic [1:0]        err_code,
    output logic [DATA_W-1:0] dev_id,
    output logic [7:0]        dev_rev
);
    localparam int TRY_W = $clog2(POLL_LIMIT + 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_LIMIT - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              pend;
        logic [TRY_W-1:0]  tries;
        logic [DATA_W-1:0] ie;
        err_e              err;
        logic [DATA_W-1:0] id;
        logic [7:0]        rev;
    } seq_t;

    seq_t d, q;

    function automatic bus_cmd_t mk(input logic wr, input logic sz,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [DATA_W-1:0] wd);
        bus_cmd_t c;
        c.write = wr;
        c.size  = sz;
        c.addr  = a;
        c.wdata = wd;
        return c;
    endfunction

    function automatic logic held(input logic [DATA_W-1:0] r);
        return r[ACC_VALID_BIT] && r[ACC_ACTIVE_BIT];
    endfunction

    function automatic logic caps_ok(input logic [DATA_W-1:0] r);
        return ((r & CAPS_MUST) == CAPS_MUST) && ((r & CAPS_ANY_OF) != '0);
    endfunction

    logic issue;
    logic fin;

    always_comb begin
        d           = q;
        cmd         = '0;
        tmr_load    = 1'b0;
        tmr_load_us = '0;
        issue       = 1'b0;
        fin         = q.pend && xfer_done;

        case (q.state)
            ST_VPOLL: begin
                cmd   = mk(1'b0, 1'b0, OFS_ACCESS, '0);
                issue = 1'b1;
                if (fin) begin
                    if (xfer_rdata[ACC_VALID_BIT]) begin
                        d.state = ST_CAP;
                    end else if (q.tries == TRY_LAST) begin
                        d.state = ST_FAIL;
                        d.err   = ERR_NOT_VALID;
                    end else begin
                        d.tries     = q.tries + 1'b1;
                        tmr_load    = 1'b1;
                        tmr_load_us = US_W'(POLL_GAP_US);
                        d.state     = ST_VWAIT;
                    end
                end
            end
            ST_VWAIT: begin
                if (tmr_expired) d.state = ST_VPOLL;
            end
            ST_CAP: begin
                cmd   = mk(1'b0, 1'b1, OFS_CAPS, '0);
                issue = 1'b1;
                if (fin) begin
                    if (xfer_rdata == '1) begin
                        d.state = ST_FAIL;
                        d.err   = ERR_ABSENT;
                    end else if (!caps_ok(xfer_rdata)) begin
                        d.state = ST_FAIL;
                        d.err   = ERR_REFUSED;
                    end else begin
                        d.state = ST_IE_RD;
                    end
                end
            end
            ST_IE_RD: begin
                cmd   = mk(1'b0, 1'b1, OFS_INTEN, '0);
                issue = 1'b1;
                if (fin) begin
                    d.ie    = xfer_rdata;
                    d.state = ST_IE_WR;
                end
            end
            ST_IE_WR: begin
                cmd   = mk(1'b1, 1'b1, OFS_INTEN, (q.ie | INTEN_SET) & ~INTEN_CLEAR);
                issue = 1'b1;
                if (fin) d.state = ST_LOC_CHK;
            end
            ST_LOC_CHK: begin
                cmd   = mk(1'b0, 1'b0, OFS_ACCESS, '0);
                issue = 1'b1;
                if (fin) d.state = held(xfer_rdata) ? ST_ID : ST_LOC_REQ;
            end
            ST_LOC_REQ: begin
                cmd   = mk(1'b1, 1'b0, OFS_ACCESS, DATA_W'(ACC_REQ_USE));
                issue = 1'b1;
                if (fin) begin
                    tmr_load    = 1'b1;
                    tmr_load_us = US_W'(LOC_TIMEOUT_US);
                    d.state     = ST_LOC_POLL;
                end
            end
            ST_LOC_POLL: begin
                cmd   = mk(1'b0, 1'b0, OFS_ACCESS, '0);
                issue = 1'b1;
                if (fin) begin
                    if (held(xfer_rdata)) begin
                        d.state = ST_ID;
                    end else if (tmr_expired) begin
                        d.state = ST_FAIL;
                        d.err   = ERR_REFUSED;
                    end
                end
            end
            ST_ID: begin
                cmd   = mk(1'b0, 1'b1, OFS_DEVID, '0);
                issue = 1'b1;
                if (fin) begin
                    d.id    = xfer_rdata;
                    d.state = ST_REV;
                end
            end
            ST_REV: begin
                cmd   = mk(1'b0, 1'b0, OFS_DEVREV, '0);
                issue = 1'b1;
                if (fin) begin
                    d.rev   = xfer_rdata[7:0];
                    d.state = ST_DONE;
                end
            end
            default: ;
        endcase

        go = issue && !q.pend;
        if (go)  d.pend = 1'b1;
        if (fin) d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_VPOLL;
            q.err   <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign init_done  = (q.state == ST_DONE);
    assign init_error = (q.state == ST_FAIL);
    assign err_code   = q.err;
    assign dev_id     = q.id;
    assign dev_rev    = q.rev;

endmodule

// File: rtl/smi_bringup.sv
module smi_bringup
    import smi_pkg::*;
#(
    parameter int CLK_MHZ        = 100,
    parameter int POLL_LIMIT     = 10000,
    parameter int POLL_GAP_US    = 10,
    parameter int LOC_TIMEOUT_US = 2000000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        req_valid,
    output logic [15:0] req_addr,
    output logic        req_write,
    output logic        req_size,
    output logic [31:0] req_wdata,
    input  logic        bus_ready,
    input  logic [31:0] bus_rdata,
    output logic        init_done,
    output logic        init_error,
    output logic [1:0]  err_code,
    output logic [31:0] dev_id,
    output logic [7:0]  dev_rev
);
    localparam int MAX_US = (LOC_TIMEOUT_US > POLL_GAP_US) ? LOC_TIMEOUT_US : POLL_GAP_US;
    localparam int US_W   = $clog2(MAX_US + 1);

    logic              go;
    bus_cmd_t          cmd;
    bus_cmd_t          req_cmd;
    logic              xfer_done;
    logic [DATA_W-1:0] xfer_rdata;
    logic              tmr_load;
    logic [US_W-1:0]   tmr_load_us;
    logic              tmr_expired;

    smi_bus_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cmd        (cmd),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .xfer_done  (xfer_done),
        .xfer_rdata (xfer_rdata)
    );

    smi_us_timer #(
        .CLK_MHZ (CLK_MHZ),
        .US_W    (US_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_us (tmr_load_us),
        .expired (tmr_expired)
    );

    smi_seq #(
        .POLL_LIMIT     (POLL_LIMIT),
        .POLL_GAP_US    (POLL_GAP_US),
        .LOC_TIMEOUT_US (LOC_TIMEOUT_US),
        .US_W           (US_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_done   (xfer_done),
        .xfer_rdata  (xfer_rdata),
        .tmr_expired (tmr_expired),
        .go          (go),
        .cmd         (cmd),
        .tmr_load    (tmr_load),
        .tmr_load_us (tmr_load_us),
        .init_done   (init_done),
        .init_error  (init_error),
        .err_code    (err_code),
        .dev_id      (dev_id),
        .dev_rev     (dev_rev)
    );

    assign req_addr  = req_cmd.addr;
    assign req_write = req_cmd.write;
    assign req_size  = req_cmd.size;
    assign req_wdata = req_cmd.wdata;

endmodule

// File: rtl/smi_bringup_chk.sv
module smi_bringup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [15:0] req_addr,
    input logic        req_write,
    input logic        req_size,
    input logic [31:0] req_wdata,
    input logic        bus_ready,
    input logic        init_done,
    input logic        init_error
);
    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !bus_ready |=> req_valid && $stable(req_addr) &&
        $stable(req_write) && $stable(req_size) && $stable(req_wdata));

    // R11
    drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && bus_ready |=> !req_valid);

    // R12
    exclusive_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done && init_error));

    // R12
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R12
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_error |=> init_error);

    // R12
    quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done || init_error) |-> !req_valid);

    // R8
    loc_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == 16'h0000 |->
        !req_size && req_wdata[7:0] == 8'h02);

    // R6
    ie_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == 16'h0008 |->
        req_size && !req_wdata[31] && req_wdata[7] && (&req_wdata[2:0]));

endmodule

bind smi_bringup smi_bringup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .bus_ready  (bus_ready),
    .init_done  (init_done),
    .init_error (init_error)
);

// File: tb/smi_bringup_tb.sv
module smi_bringup_tb;
    localparam int MHZ   = 3;
    localparam int PLIM  = 6;
    localparam int GAP   = 2;
    localparam int LOCUS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_write, req_size;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        init_done, init_error;
    logic [1:0]  err_code;
    logic [31:0] dev_id;
    logic [7:0]  dev_rev;

    always #4 clk = ~clk;

    smi_bringup #(.CLK_MHZ(MHZ), .POLL_LIMIT(PLIM), .POLL_GAP_US(GAP),
                  .LOC_TIMEOUT_US(LOCUS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .init_done(init_done),
        .init_error(init_error), .err_code(err_code), .dev_id(dev_id),
        .dev_rev(dev_rev));

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        logic [15:0] a;
        bit          w;
        bit          sz;
        logic [31:0] d;
        string       tag;
    } txn_t;
    txn_t expq[$];

    // scenario configuration
    int          c_valid_after, c_grant_after, c_wait;
    logic [31:0] c_cap, c_ie, c_id;
    logic [7:0]  c_rev;
    bit          c_held;
    // slave state
    int          acc_reads, polls, wcnt;
    bit          valid_now, held_now, req_seen, open_poll, vphase;
    logic [31:0] ie_reg;
    int          last_vpoll, req_cyc, err_cyc;
    bit          err_seen;
    int          exp_code;

    task automatic push(input logic [15:0] a, input bit w, input bit sz,
                        input logic [31:0] d, input string tag);
        txn_t t;
        t.a = a; t.w = w; t.sz = sz; t.d = d; t.tag = tag;
        expq.push_back(t);
    endtask

    task automatic build_exp();
        expq.delete();
        open_poll = 0;
        if (c_valid_after > PLIM) begin
            for (int i = 0; i < PLIM; i++) push(16'h0000, 0, 0, 0, "R3");
            exp_code = 1;
            return;
        end
        for (int i = 0; i < c_valid_after; i++) push(16'h0000, 0, 0, 0, "R2");
        push(16'h0014, 0, 1, 0, "R4");
        if (c_cap == 32'hFFFF_FFFF) begin exp_code = 2; return; end
        if ((c_cap & 32'h15) != 32'h15 || (c_cap & 32'h30) == 0) begin
            exp_code = 3; return;
        end
        push(16'h0008, 0, 1, 0, "R6");
        push(16'h0008, 1, 1, (c_ie | 32'h87) & 32'h7FFF_FFFF, "R6");
        push(16'h0000, 0, 0, 0, "R7");
        if (!c_held) begin
            push(16'h0000, 1, 0, 32'h02, "R8");
            if (c_grant_after < 0) begin exp_code = 3; return; end
            for (int i = 0; i < c_grant_after; i++) push(16'h0000, 0, 0, 0, "R8");
        end
        push(16'h0F00, 0, 1, 0, "R10");
        push(16'h0F04, 0, 0, 0, "R10");
        exp_code = 0;
    endtask

    function automatic logic [31:0] slave_read(input logic [15:0] a);
        case (a)
            16'h0000: begin
                acc_reads++;
                if (!valid_now && acc_reads >= c_valid_after) valid_now = 1;
                if (valid_now && req_seen && !held_now) begin
                    polls++;
                    if (c_grant_after >= 0 && polls >= c_grant_after) held_now = 1;
                end
                return {24'h0, valid_now, 1'b0, valid_now && held_now, 5'h0};
            end
            16'h0014: return c_cap;
            16'h0008: return ie_reg;
            16'h0F00: return c_id;
            16'h0F04: return {24'hABCDEF, c_rev};
            default:  return 32'hDEAD_BEEF;
        endcase
    endfunction

    task automatic handle_txn();
        txn_t t;
        if (req_addr == 16'h0000 && !req_write && !valid_now) begin
            if (vphase && acc_reads > 0 && cyc - last_vpoll < GAP * MHZ)
                check("R2", "poll spacing", cyc - last_vpoll, GAP * MHZ);
            last_vpoll = cyc;
        end
        if (req_write) begin
            if (req_addr == 16'h0008) ie_reg = req_wdata;
            if (req_addr == 16'h0000 && req_wdata[7:0] == 8'h02) begin
                req_seen = 1; req_cyc = cyc;
                if (c_grant_after < 0) open_poll = 1;
            end
            bus_rdata = 32'h0;
        end else begin
            bus_rdata = slave_read(req_addr);
        end
        if (open_poll && !req_write && req_addr == 16'h0000 && expq.size() == 0) begin
            return;
        end
        if (expq.size() == 0) begin
            check("R12", "unexpected access addr", req_addr, 16'hFFFF);
            return;
        end
        t = expq.pop_front();
        check(t.tag, "access addr", req_addr, t.a);
        check(t.tag, "access dir", req_write, t.w);
        check(t.tag, "access size", req_size, t.sz);
        if (t.w) check(t.tag, "write data", req_wdata, t.d);
    endtask

    // bus slave and per-clock output comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 0;
            wcnt = 0;
        end else begin
            if (expq.size() != 0 && (init_done || init_error))
                check("R12", "end flag with accesses pending", 1, 0);
            if (init_error && !err_seen) begin err_seen = 1; err_cyc = cyc; end
            if (bus_ready) begin
                bus_ready = 0;
            end else if (req_valid) begin
                if (wcnt < c_wait) wcnt++;
                else begin
                    wcnt = 0;
                    handle_txn();
                    bus_ready = 1;
                end
            end
        end
    end

    task automatic run(input string name);
        $display("[TB] scenario %s", name);
        rst_n = 0;
        acc_reads = 0; polls = 0; valid_now = 0; held_now = c_held;
        req_seen = 0; ie_reg = c_ie; vphase = 1; last_vpoll = 0;
        err_seen = 0; err_cyc = 0; req_cyc = 0;
        build_exp();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check("R1", "valid in reset", req_valid, 0);
        check("R1", "done in reset", init_done, 0);
        check("R1", "error in reset", init_error, 0);
        check("R1", "code in reset", err_code, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "done after reset", init_done, 0);
        for (int i = 0; i < 3000 && !(init_done || init_error); i++) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_valid) check("R12", "request after end", 1, 0);
        end
        check("R12", "remaining accesses", expq.size(), 0);
        check(exp_code == 0 ? "R10" : "R12", "done flag", init_done, exp_code == 0);
        check(exp_code == 1 ? "R3" : exp_code == 2 ? "R4" : "R5", "error code", err_code, exp_code);
        check("R12", "error flag", init_error, exp_code != 0);
        if (exp_code == 0) begin
            check("R10", "dev_id", dev_id, c_id);
            check("R10", "dev_rev", dev_rev, c_rev);
        end
    endtask

    initial begin
        fork
            begin
                c_wait = 0; c_valid_after = 1; c_cap = 32'h35; c_ie = 32'h0;
                c_held = 1; c_grant_after = 0; c_id = 32'h1234_5678; c_rev = 8'h21;
                run("held locality");

                c_wait = 2; c_valid_after = 4; c_cap = 32'h15; c_ie = 32'h8000_0000;
                c_held = 0; c_grant_after = 2; c_id = 32'hCAFE_0102; c_rev = 8'h07;
                run("slow slave, locality request");

                c_wait = 1; c_valid_after = PLIM; c_cap = 32'h1F5; c_ie = 32'h1234_5600;
                c_held = 1; c_id = 32'h0BAD_F00D; c_rev = 8'hFE;
                run("validity on last poll");

                c_wait = 0; c_valid_after = 100;
                run("validity timeout R3");

                c_valid_after = 2; c_cap = 32'hFFFF_FFFF;
                run("absent device R4");

                c_valid_after = 1; c_cap = 32'h11;
                run("capability bit 2 missing R5");

                c_cap = 32'h25;
                run("capability bit 4 missing R5");

                c_cap = 32'h35; c_held = 0; c_grant_after = -1;
                run("locality timeout R9");
                check("R9", "error reached", err_seen, 1);
                // R9: error rises at least the timeout after the request, within one poll period plus pipeline
                check("R9", "timeout not early", (err_cyc - req_cyc) >= LOCUS * MHZ, 1);
                check("R9", "timeout not late", (err_cyc - req_cyc) <= LOCUS * MHZ + 8, 1);
            end
            begin
                repeat (150000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule